// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block is the timing core of a tile-based LCD controller. It steps through four display phases on every dot clock: sprite-table search, pixel transfer, horizontal blank and vertical blank. It keeps the current scanline number and a line-compare value. It also keeps a status byte that holds four interrupt enables, a line-match flag and the current phase code. It issues a vertical-blank request and a shared status request. Each request is a single-cycle pulse.

Software reaches the block through a byte bus with two addresses, status and compare. Reads are combinational from the selected address. Writes take effect at the next clock edge. Phase and line counts are parameters. The defaults give a 456-dot line: 80 dots of sprite search, 172 of transfer and 204 of horizontal blank. There are 144 visible lines followed by 10 blanking lines. Reset is asynchronous and active-low, and its release is synchronised inside the block. The first dot is counted on the third rising edge after the reset input goes high.

Top module: `lcd_mode_seq`

## Requirements
- R1: While held in reset, the block shows phase code 2 (sprite search) and line 0. No request is active, the status byte reads 0x02 and the compare byte reads 0x00.
- R2: On each visible line the phase code (mode_o, bits 1:0 of status) goes through these states in order:
  - 2 for OAM_DOTS cycles;
  - 3 for XFER_DOTS cycles;
  - 0 for HBL_DOTS cycles.
- R3: line_o advances by one at the end of every line of LINE_DOTS = OAM_DOTS+XFER_DOTS+HBL_DOTS cycles. Lines VIS_LINES to TOTAL_LINES-1 show phase code 1 for the whole line. After line TOTAL_LINES-1 the counter returns to 0 in phase 2.
- R4: vblank_irq is high for exactly one cycle: the first cycle in which mode_o shows 1. It does not depend on any enable bit.
- R5: stat_irq is high for one cycle on the first cycle of a phase when that phase's enable bit is set. The enables are bit 3 for phase 0, bit 4 for phase 1 and bit 5 for phase 2, including the return to line 0. The enables sampled are the values held before that edge. Phase 3 never raises it.
- R6: Status bit 2 (match flag) becomes (line == compare) at every line change while bit 6 is set. While bit 6 is clear it holds its value.
- R7: A write to the compare address with bit 6 set refreshes the flag against the line in effect after that edge and the newly written value. With bit 6 clear the flag is unchanged.
- R8: bus_addr 0 selects status and reads {0, bits 6:3 enables, bit 2 flag, bits 1:0 phase}. bus_addr 1 selects the compare byte. A status write changes only bits 6:3. Bit 7 always reads 0, and the flag and phase bits ignore written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the byte bus |
| bus_addr | input | 1 | Register select: 0 status, 1 compare |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| line_o | output | 8 | Current scanline |
| mode_o | output | 2 | Current phase code |
| vblank_irq | output | 1 | Vertical-blank request pulse |
| stat_irq | output | 1 | Shared status request pulse |

## Verification
A wrong dot count or phase transition shows on mode_o in the very cycle it happens. A wrong line counter shows on line_o at the next line boundary and moves the vertical-blank pulse by whole lines. A badly gated or misrouted enable shows as a missing or extra stat_irq pulse at the first phase entry of the affected kind, which comes within one line. A wrong match-flag refresh stays hidden until status is read; the bench reads it back every cycle, so the error appears on the first line change or compare write after it.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    MD_HBL  = 2'd0,
    MD_VBL  = 2'd1,
    MD_OAM  = 2'd2,
    MD_XFER = 2'd3
  } lcd_mode_e;

  localparam logic REG_STAT = 1'b0;
  localparam logic REG_CMP  = 1'b1;
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int unsigned VIS_LINES   = 144,
  parameter int unsigned TOTAL_LINES = 154,
  parameter int unsigned LW          = $clog2(TOTAL_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] line_d,
  output logic          frame_wrap,
  output logic          nxt_in_vbl
);
  localparam logic [LW-1:0] LAST_LINE = LW'(TOTAL_LINES - 1);
  localparam logic [LW-1:0] FIRST_VBL = LW'(VIS_LINES);

  always_comb begin
    frame_wrap = line_end && (line_q == LAST_LINE);
    line_d     = line_q;
    if (line_end) line_d = frame_wrap ? '0 : line_q + 1'b1;
    nxt_in_vbl = (line_d >= FIRST_VBL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_q <= '0;
    else if (line_end) line_q <= line_d;
  end

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LAST_LINE);
endmodule

// File: rtl/lcd_dot_timer.sv
module lcd_dot_timer
  import lcd_seq_pkg::*;
#(
  parameter int unsigned OAM_DOTS  = 80,
  parameter int unsigned XFER_DOTS = 172,
  parameter int unsigned HBL_DOTS  = 204
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      nxt_in_vbl,
  input  logic      frame_wrap,
  output lcd_mode_e mode_q,
  output logic      line_end,
  output logic      enter_hbl,
  output logic      enter_vbl,
  output logic      enter_oam
);
  localparam int unsigned LINE_DOTS = OAM_DOTS + XFER_DOTS + HBL_DOTS;
  localparam int unsigned DW        = $clog2(LINE_DOTS);
  localparam logic [DW-1:0] OAM_LAST  = DW'(OAM_DOTS - 1);
  localparam logic [DW-1:0] XFER_LAST = DW'(OAM_DOTS + XFER_DOTS - 1);
  localparam logic [DW-1:0] LINE_LAST = DW'(LINE_DOTS - 1);

  logic [DW-1:0] dot_q, dot_d;
  lcd_mode_e     mode_d;
  logic          mode_ce;

  always_comb begin
    line_end  = (dot_q == LINE_LAST);
    dot_d     = line_end ? '0 : dot_q + 1'b1;
    mode_d    = mode_q;
    enter_hbl = 1'b0;
    enter_vbl = 1'b0;
    enter_oam = 1'b0;
    unique case (mode_q)
      MD_OAM:  if (dot_q == OAM_LAST) mode_d = MD_XFER;
      MD_XFER: if (dot_q == XFER_LAST) begin
                 mode_d    = MD_HBL;
                 enter_hbl = 1'b1;
               end
      MD_HBL:  if (line_end) begin
                 if (nxt_in_vbl) begin
                   mode_d    = MD_VBL;
                   enter_vbl = 1'b1;
                 end else begin
                   mode_d    = MD_OAM;
                   enter_oam = 1'b1;
                 end
               end
      MD_VBL:  if (frame_wrap) begin
                 mode_d    = MD_OAM;
                 enter_oam = 1'b1;
               end
      default: mode_d = MD_OAM;
    endcase
    mode_ce = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      mode_q <= MD_OAM;
    end else begin
      dot_q <= dot_d;
      if (mode_ce) mode_q <= mode_d;
    end
  end

  // R2
  oam_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_OAM) |=> (mode_q == MD_OAM || mode_q == MD_XFER));
  // R2
  xfer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_XFER) |=> (mode_q == MD_XFER || mode_q == MD_HBL));
  // R3
  vbl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_VBL) |=> (mode_q == MD_VBL || mode_q == MD_OAM));
endmodule

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
  import lcd_seq_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  lcd_mode_e     mode,
  input  logic [LW-1:0] line_q,
  input  logic [LW-1:0] line_d,
  input  logic          line_end,
  input  logic          enter_hbl,
  input  logic          enter_vbl,
  input  logic          enter_oam,
  output logic          vblank_irq,
  output logic          stat_irq
);
  // en_q: [0] hblank, [1] vblank, [2] sprite search, [3] line match
  logic [3:0] en_q, en_d;
  logic [7:0] cmp_q, cmp_d;
  logic       match_q, match_d;
  logic       wr_stat, wr_cmp, refresh, stat_req;
  logic [7:0] line_now;

  always_comb begin
    wr_stat  = bus_wr && (bus_addr == REG_STAT);
    wr_cmp   = bus_wr && (bus_addr == REG_CMP);
    en_d     = wr_stat ? bus_wdata[6:3] : en_q;
    cmp_d    = wr_cmp ? bus_wdata : cmp_q;
    line_now = 8'(line_end ? line_d : line_q);
    refresh  = en_q[3] && (line_end || wr_cmp);
    match_d  = refresh ? (line_now == cmp_d) : match_q;
    stat_req = (enter_hbl && en_q[0]) || (enter_vbl && en_q[1]) ||
               (enter_oam && en_q[2]);
    bus_rdata = (bus_addr == REG_CMP) ? cmp_q : {1'b0, en_q, match_q, mode};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      cmp_q      <= '0;
      match_q    <= 1'b0;
      vblank_irq <= 1'b0;
      stat_irq   <= 1'b0;
    end else begin
      if (wr_stat) en_q    <= en_d;
      if (wr_cmp)  cmp_q   <= cmp_d;
      if (refresh) match_q <= match_d;
      vblank_irq <= enter_vbl;
      stat_irq   <= stat_req;
    end
  end

  // R6
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[3] |=> $stable(match_q));
  // R4
  vbl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);
  // R4
  vbl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (mode == MD_VBL));
  // R5
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |-> (mode != MD_XFER));
endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned OAM_DOTS    = 80,
  parameter int unsigned XFER_DOTS   = 172,
  parameter int unsigned HBL_DOTS    = 204,
  parameter int unsigned VIS_LINES   = 144,
  parameter int unsigned TOTAL_LINES = 154
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] line_o,
  output logic [1:0] mode_o,
  output logic       vblank_irq,
  output logic       stat_irq
);
  localparam int unsigned LW = $clog2(TOTAL_LINES);

  logic          rst_n_sync;
  logic [LW-1:0] line_q, line_d;
  logic          frame_wrap, nxt_in_vbl, line_end;
  logic          enter_hbl, enter_vbl, enter_oam;
  lcd_mode_e     mode_q;

  lcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lcd_line_ctr #(
    .VIS_LINES   (VIS_LINES),
    .TOTAL_LINES (TOTAL_LINES),
    .LW          (LW)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .line_end   (line_end),
    .line_q     (line_q),
    .line_d     (line_d),
    .frame_wrap (frame_wrap),
    .nxt_in_vbl (nxt_in_vbl)
  );

  lcd_dot_timer #(
    .OAM_DOTS  (OAM_DOTS),
    .XFER_DOTS (XFER_DOTS),
    .HBL_DOTS  (HBL_DOTS)
  ) u_dot (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .nxt_in_vbl (nxt_in_vbl),
    .frame_wrap (frame_wrap),
    .mode_q     (mode_q),
    .line_end   (line_end),
    .enter_hbl  (enter_hbl),
    .enter_vbl  (enter_vbl),
    .enter_oam  (enter_oam)
  );

  lcd_stat_regs #(
    .LW (LW)
  ) u_stat (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mode       (mode_q),
    .line_q     (line_q),
    .line_d     (line_d),
    .line_end   (line_end),
    .enter_hbl  (enter_hbl),
    .enter_vbl  (enter_vbl),
    .enter_oam  (enter_oam),
    .vblank_irq (vblank_irq),
    .stat_irq   (stat_irq)
  );

  assign line_o = 8'(line_q);
  assign mode_o = mode_q;

  // R3
  vbl_line_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q == MD_VBL) |-> (line_q >= LW'(VIS_LINES)));
  // R3
  vis_line_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_q != MD_VBL) |-> (line_q < LW'(VIS_LINES)));
endmodule

// File: tb/sim_lcd_mode_seq.sv
`timescale 1ns/1ps
module sim_lcd_mode_seq;
  localparam int OAM = 3, XFER = 5, HBL = 4, VIS = 3, TOT = 5;
  localparam int LINE = OAM + XFER + HBL;
  localparam int FRAME = LINE * TOT;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata, line_o;
  logic [1:0] mode_o;
  logic       vblank_irq, stat_irq;

  int n_chk = 0, n_bad = 0, n = 0;
  bit done = 0;
  logic [3:0] m_en = '0;
  logic [7:0] m_cmp = '0;
  logic       m_match = 1'b0;
  int e_line = 0, e_mode = 2, e_vbl = 0, e_stat = 0;

  always #2.5 clk = ~clk;

  lcd_mode_seq #(.OAM_DOTS(OAM), .XFER_DOTS(XFER), .HBL_DOTS(HBL),
                 .VIS_LINES(VIS), .TOTAL_LINES(TOT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_o(line_o),
    .mode_o(mode_o), .vblank_irq(vblank_irq), .stat_irq(stat_irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at dot %0d: actual=%0d expected=%0d", req, n, act, exp);
    end
  endtask

  function automatic void calc(input int k, output int ln, output int md);
    int q = k % FRAME;
    int d = q % LINE;
    ln = q / LINE;
    if (ln >= VIS)            md = 1;
    else if (d < OAM)         md = 2;
    else if (d < OAM + XFER)  md = 3;
    else                      md = 0;
  endfunction

  task automatic check_all();
    chk("R2 mode", int'(mode_o), e_mode);
    chk("R3 line", int'(line_o), e_line);
    chk("R4 vblank_irq", int'(vblank_irq), e_vbl);
    chk("R5 stat_irq", int'(stat_irq), e_stat);
    bus_addr = 1'b0;
    #1 chk("R6 R7 R8 status", int'(bus_rdata),
           int'({1'b0, m_en, m_match, 2'(e_mode)}));
    bus_addr = 1'b1;
    #1 chk("R8 compare", int'(bus_rdata), int'(m_cmp));
    bus_addr = 1'b0;
  endtask

  // one dot: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input logic wr, input logic a, input logic [7:0] d);
    int ln0, md0, ln1, md1;
    logic [3:0] en_old;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    calc(n, ln0, md0);
    n++;
    calc(n, ln1, md1);
    en_old = m_en;
    if (wr && a) m_cmp = d;
    if (en_old[3] && ((ln1 != ln0) || (wr && a))) m_match = (ln1 == int'(m_cmp));
    if (wr && !a) m_en = d[6:3];
    e_line = ln1; e_mode = md1;
    e_vbl  = (md1 == 1 && md0 != 1) ? 1 : 0;
    e_stat = (md1 != md0) && ((md1 == 0 && en_old[0]) || (md1 == 1 && en_old[1]) ||
                              (md1 == 2 && en_old[2])) ? 1 : 0;
    @(negedge clk);
    bus_wr = 1'b0;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mode", int'(mode_o), 2);
    chk("R1 line", int'(line_o), 0);
    chk("R1 irqs", int'({vblank_irq, stat_irq}), 0);
    #1 chk("R1 status", int'(bus_rdata), 8'h02);
    bus_addr = 1'b1;
    #1 chk("R1 compare", int'(bus_rdata), 0);
    bus_addr = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_all();
    // enables off: plain sequencing over two frames, irq only for vblank
    for (int i = 0; i < 2 * FRAME; i++) cyc(1'b0, 1'b0, 8'h00);
    // sweep every enable pattern; bit 7 and bits 2:0 of the write are junk
    for (int p = 0; p < 16; p++) begin
      cyc(1'b1, 1'b0, {1'b1, 4'(p), 3'b111});
      cyc(1'b1, 1'b1, 8'(p % (TOT + 1)));
      for (int i = 0; i < FRAME; i++) begin
        if (i == FRAME / 2 + (p % 7)) begin
          int ln, md;
          calc(n + 1, ln, md);
          cyc(1'b1, 1'b1, 8'(ln));         // R7: compare write hits current line
        end else if (i == FRAME / 3) begin
          cyc(1'b1, 1'b1, 8'hEE);          // R7: compare write that cannot match
        end else begin
          cyc(1'b0, 1'b0, 8'h00);
        end
      end
    end
    // compare write at the exact line boundary (R7 with a line change)
    cyc(1'b1, 1'b0, 8'h40);
    while ((n + 1) % LINE != 0) cyc(1'b0, 1'b0, 8'h00);
    begin
      int ln, md;
      calc(n + 1, ln, md);
      cyc(1'b1, 1'b1, 8'(ln));
    end
    for (int i = 0; i < FRAME; i++) cyc(1'b0, 1'b0, 8'h00);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule